// File: doc/BRIEF.md
# Chained-Block DMA Transmit Engine

This block is one transmit direction of a DMA channel. It reads memory in bursts of one to four 32-bit words and hands the data to a 16-bit device bus. Software gives it two address pointers: the pointer in use and the pointer to the block that follows. The two blocks do not have to be adjacent in memory. The pointer in use moves forward after every burst. When it crosses a block boundary, the engine switches to the waiting pointer in the same step and keeps streaming with no stall. It also raises a pointer-update flag, so software can load the pointer for the block after that.

If a block ends before software has refreshed the waiting pointer, the engine reports an overrun. It then stops issuing requests until software clears the overrun flag. Software controls the engine through a small write-only register port. A run bit starts and stops the transfer. A field sets the number of words per burst. Two sticky flags are cleared by writing 1 to them.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, `mem_req`, `dev_valid`, `busy`, `irq`, `upd_flag`, `ovr_flag` and `next_valid` are all 0.
- R2: Each memory request carries the current pointer on `mem_addr` and a word count on `mem_len` equal to the control field bits [3:2] plus 1. Control is register address 0: bit 0 is run, bit 1 is the interrupt enable. After each burst the current pointer advances by 4 times the word count.
- R3: Every word fetched is sent on the device bus as two halfwords, bits [15:0] first and bits [31:16] second. A halfword transfers on a cycle with `dev_valid` and `dev_ready` both high. `dev_data` holds steady while `dev_valid` is high and `dev_ready` is low. All 2×count halfwords of a burst are delivered.
- R4: A burst whose advanced pointer lands in a different BLOCK_BYTES-aligned block ends the block. If `next_valid` is 1, the next pointer becomes the current pointer, `next_valid` clears and `upd_flag` sets. The following request uses the new pointer.
- R5: If a block ends while `next_valid` is 0, `ovr_flag` sets and the current pointer keeps its advanced value. No request is issued while `ovr_flag` is 1. Once it is cleared with run still set, requests resume at the current pointer.
- R6: Status is register address 2. Writing a 1 to bit 0 clears `upd_flag`. Writing a 1 to bit 1 clears `ovr_flag`. Writing 0 to a bit leaves that flag unchanged.
- R7: `irq` is high exactly when `upd_flag` and the interrupt enable bit are both 1.
- R8: Clearing run during a burst lets that burst finish in full. No further request follows, and both pointers then stay unchanged.
- R9: Writing register address 1 loads the next pointer and sets `next_valid`. Promotion clears it. Register address 3 loads the current pointer.
- R10: Once raised, `mem_req` stays high with `mem_addr` and `mem_len` stable until a cycle with `mem_gnt` high. The `mem_len` read words then arrive on cycles with `mem_rvalid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 next pointer, 2 status, 3 current pointer |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Burst read request |
| mem_gnt | input | 1 | Request accepted |
| mem_addr | output | ADDR_W | Byte address of the burst |
| mem_len | output | $clog2(MAX_WORDS+1) | Words in the burst |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |
| dev_valid | output | 1 | Halfword available to the device |
| dev_ready | input | 1 | Device accepts the halfword |
| dev_data | output | 16 | Halfword to the device |
| cur_ptr | output | ADDR_W | Current pointer |
| next_valid | output | 1 | Next pointer loaded and not yet used |
| upd_flag | output | 1 | Sticky pointer-update flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| busy | output | 1 | A burst is in progress |
| irq | output | 1 | Pointer-update interrupt |

## Verification
The hardest case to reach is the overrun. It needs a full block to pass after a promotion with no write to the next pointer. The bench arms exactly one next pointer and waits for the first promotion. It then lets the second block run to its boundary and checks that requests stop and the pointer stays at the boundary. A later refresh and clear must restart the engine at that pointer. The disable-in-flight case is timed from the ports: run is cleared after `dev_valid` is first seen, while the device is throttled so the burst is still draining.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_FILL,
        ST_DRAIN,
        ST_DONE
    } eng_state_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_NEXT = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_CUR  = 2'd3;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_IEN_BIT = 1;
    localparam int CTRL_LEN_LSB = 2;
    localparam int STAT_UPD_BIT = 0;
    localparam int STAT_OVR_BIT = 1;

    typedef struct packed {
        logic run;
        logic irq_en;
    } ctrl_bits_t;

    function automatic logic [15:0] pick_half(input logic [31:0] word, input logic upper);
        return upper ? word[31:16] : word[15:0];
    endfunction

endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 4096,
    parameter int BL_W        = 2,
    parameter int LEN_W       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              burst_done,
    input  logic [LEN_W-1:0]  burst_words,
    output ctrl_bits_t        ctrl,
    output logic [BL_W-1:0]   len_m1,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              next_valid,
    output logic              upd_flag,
    output logic              ovr_flag
);
    localparam int BLK_W = $clog2(BLOCK_BYTES);

    logic [ADDR_W-1:0] next_ptr;
    logic [ADDR_W-1:0] adv_ptr;
    logic              crosses;

    always_comb begin
        adv_ptr = cur_ptr + {{(ADDR_W-LEN_W-2){1'b0}}, burst_words, 2'b00};
        crosses = adv_ptr[ADDR_W-1:BLK_W] != cur_ptr[ADDR_W-1:BLK_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            len_m1     <= '0;
            cur_ptr    <= '0;
            next_ptr   <= '0;
            next_valid <= 1'b0;
            upd_flag   <= 1'b0;
            ovr_flag   <= 1'b0;
        end else begin
            if (burst_done) begin
                if (crosses && next_valid) begin
                    cur_ptr    <= next_ptr;
                    next_valid <= 1'b0;
                    upd_flag   <= 1'b1;
                end else begin
                    cur_ptr <= adv_ptr;
                    if (crosses) begin
                        ovr_flag <= 1'b1;
                    end
                end
            end
            if (reg_we) begin
                unique case (reg_addr)
                    RA_CTRL: begin
                        ctrl.run    <= reg_wdata[CTRL_RUN_BIT];
                        ctrl.irq_en <= reg_wdata[CTRL_IEN_BIT];
                        len_m1      <= reg_wdata[CTRL_LEN_LSB +: BL_W];
                    end
                    RA_NEXT: begin
                        next_ptr   <= reg_wdata[ADDR_W-1:0];
                        next_valid <= 1'b1;
                    end
                    RA_STAT: begin
                        if (reg_wdata[STAT_UPD_BIT]) upd_flag <= 1'b0;
                        if (reg_wdata[STAT_OVR_BIT]) ovr_flag <= 1'b0;
                    end
                    RA_CUR: cur_ptr <= reg_wdata[ADDR_W-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_chain_buf.sv
module dma_chain_buf
    import dma_chain_pkg::*;
#(
    parameter int MAX_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_word,
    input  logic             rd_upper,
    output logic [15:0]      rd_half
);
    logic [31:0] words [MAX_WORDS];

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                words[g] <= wr_data;
            end
        end
    end

    always_comb rd_half = pick_half(words[rd_word], rd_upper);
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 3,
    parameter int BL_W   = 2,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              halted,
    input  logic [BL_W-1:0]   len_m1,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic              dev_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [IDX_W-1:0]  rd_word,
    output logic              rd_upper,
    output logic              dev_valid,
    output logic              burst_done,
    output logic              busy
);
    localparam logic [LEN_W:0] ONE_HALF = (LEN_W+1)'(1);

    eng_state_e       state;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] beat_q;
    logic [LEN_W:0]   half_q;
    logic [LEN_W:0]   last_half;
    logic [LEN_W-1:0] beat_nx;

    always_comb begin
        last_half = {len_q, 1'b0} - ONE_HALF;
        beat_nx   = beat_q + LEN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            len_q    <= '0;
            beat_q   <= '0;
            half_q   <= '0;
            mem_addr <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (run && !halted) begin
                    mem_addr <= cur_ptr;
                    len_q    <= LEN_W'(len_m1) + LEN_W'(1);
                    state    <= ST_REQ;
                end
                ST_REQ: if (mem_gnt) begin
                    beat_q <= '0;
                    state  <= ST_FILL;
                end
                ST_FILL: if (mem_rvalid) begin
                    beat_q <= beat_nx;
                    if (beat_nx == len_q) begin
                        half_q <= '0;
                        state  <= ST_DRAIN;
                    end
                end
                ST_DRAIN: if (dev_ready) begin
                    if (half_q == last_half) state <= ST_DONE;
                    else half_q <= half_q + ONE_HALF;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req    = state == ST_REQ;
        mem_len    = len_q;
        buf_we     = state == ST_FILL && mem_rvalid;
        buf_idx    = beat_q[IDX_W-1:0];
        rd_word    = half_q[IDX_W:1];
        rd_upper   = half_q[0];
        dev_valid  = state == ST_DRAIN;
        burst_done = state == ST_DONE;
        busy       = state != ST_IDLE;
    end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 4096,
    parameter int MAX_WORDS   = 4,
    localparam int LEN_W      = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              dev_valid,
    input  logic              dev_ready,
    output logic [15:0]       dev_data,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              next_valid,
    output logic              upd_flag,
    output logic              ovr_flag,
    output logic              busy,
    output logic              irq
);
    localparam int BL_W  = $clog2(MAX_WORDS);
    localparam int IDX_W = BL_W;

    ctrl_bits_t       ctrl;
    logic [BL_W-1:0]  len_m1;
    logic             burst_done;
    logic             buf_we;
    logic [IDX_W-1:0] buf_idx;
    logic [IDX_W-1:0] rd_word;
    logic             rd_upper;

    dma_chain_regs #(
        .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .BL_W(BL_W), .LEN_W(LEN_W)
    ) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .burst_done(burst_done), .burst_words(mem_len),
        .ctrl(ctrl), .len_m1(len_m1), .cur_ptr(cur_ptr), .next_valid(next_valid),
        .upd_flag(upd_flag), .ovr_flag(ovr_flag)
    );

    dma_chain_ctrl #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BL_W(BL_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .run(ctrl.run), .halted(ovr_flag), .len_m1(len_m1),
        .cur_ptr(cur_ptr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .dev_ready(dev_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .buf_we(buf_we), .buf_idx(buf_idx), .rd_word(rd_word),
        .rd_upper(rd_upper), .dev_valid(dev_valid), .burst_done(burst_done),
        .busy(busy)
    );

    dma_chain_buf #(
        .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W)
    ) u_buf (
        .clk(clk), .rst(rst), .wr_en(buf_we), .wr_idx(buf_idx), .wr_data(mem_rdata),
        .rd_word(rd_word), .rd_upper(rd_upper), .rd_half(dev_data)
    );

    always_comb irq = upd_flag && ctrl.irq_en;
endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 3,
    parameter int MAX_WORDS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_len,
    input logic              dev_valid,
    input logic              dev_ready,
    input logic [15:0]       dev_data,
    input logic              next_valid,
    input logic              upd_flag,
    input logic              ovr_flag,
    input logic              irq
);
    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len));

    a_r3_half_held: assert property (@(posedge clk) disable iff (rst)
        dev_valid && !dev_ready |=> dev_valid && $stable(dev_data));

    a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_len >= LEN_W'(1) && mem_len <= LEN_W'(MAX_WORDS));

    a_r5_halt_no_req: assert property (@(posedge clk) disable iff (rst)
        ovr_flag |-> !mem_req);

    a_r4_promote_flags: assert property (@(posedge clk) disable iff (rst)
        $fell(next_valid) |-> upd_flag);

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> upd_flag);

    a_r1_phase_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && dev_valid));
endmodule

bind dma_chain_engine dma_chain_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS)
) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_len(mem_len), .dev_valid(dev_valid),
    .dev_ready(dev_ready), .dev_data(dev_data), .next_valid(next_valid),
    .upd_flag(upd_flag), .ovr_flag(ovr_flag), .irq(irq)
);

// File: tb/tb_dma_chain_engine.sv
module tb_dma_chain_engine;
    localparam int ADDR_W = 32;
    localparam int BLK    = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_gnt, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic [2:0]  mem_len;
    logic        dev_valid, dev_ready;
    logic [15:0] dev_data;
    logic [31:0] cur_ptr;
    logic        next_valid, upd_flag, ovr_flag, busy, irq;

    dma_chain_engine #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLK), .MAX_WORDS(4)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .dev_valid(dev_valid), .dev_ready(dev_ready),
        .dev_data(dev_data), .cur_ptr(cur_ptr), .next_valid(next_valid),
        .upd_flag(upd_flag), .ovr_flag(ovr_flag), .busy(busy), .irq(irq)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int rdy_mode = 0;
    int gnt_wait = 0;
    int cyc = 0;
    logic [31:0] log_addr [256];
    logic [2:0]  log_len [256];
    int log_n = 0;
    logic [15:0] exp_hw [1024];
    int exp_wr = 0;
    int exp_rd = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: optional grant delay, data word = {~addr[15:0], addr[15:0]}
    initial begin
        mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (mem_req) begin
                logic [31:0] a;
                int n;
                a = mem_addr;
                n = int'(mem_len);
                for (int k = 0; k < gnt_wait; k++) @(negedge clk);
                chk("R10 addr held until grant", mem_addr, a);
                mem_gnt = 1'b1;
                if (log_n < 256) begin
                    log_addr[log_n] = a; log_len[log_n] = mem_len;
                end
                log_n++;
                @(negedge clk);
                mem_gnt = 1'b0;
                for (int i = 0; i < n; i++) begin
                    logic [31:0] wa;
                    wa = a + 32'(4 * i);
                    mem_rvalid = 1'b1;
                    mem_rdata = {~wa[15:0], wa[15:0]};
                    exp_hw[exp_wr % 1024] = wa[15:0];
                    exp_hw[(exp_wr + 1) % 1024] = ~wa[15:0];
                    exp_wr += 2;
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    // device sink: checks halfword order (R3)
    initial begin
        dev_ready = 1'b0;
        forever begin
            @(negedge clk);
            dev_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
            if (!rst && dev_valid && dev_ready) begin
                if (exp_rd == exp_wr) chk("R3 unexpected halfword", 32'(dev_data), 32'hFFFF_FFFF);
                else begin
                    chk("R3 halfword order", 32'(dev_data), 32'(exp_hw[exp_rd % 1024]));
                    exp_rd++;
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_for_upd();
        for (int i = 0; i < 20000 && !upd_flag; i++) @(negedge clk);
    endtask

    task automatic stop_engine();
        wr(2'd0, 32'h0);
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R3 every fetched halfword delivered", 32'(exp_rd), 32'(exp_wr));
    endtask

    task automatic fresh();
        stop_engine();
        wr(2'd2, 32'h3);
        log_n = 0;
    endtask

    task automatic t_reset();
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 dev_valid", 32'(dev_valid), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 upd_flag", 32'(upd_flag), 0);
        chk("R1 ovr_flag", 32'(ovr_flag), 0);
        chk("R1 next_valid", 32'(next_valid), 0);
    endtask

    task automatic t_chain4();
        fresh();
        rdy_mode = 0; gnt_wait = 2;
        wr(2'd3, 32'h1000);
        wr(2'd1, 32'h2000);
        chk("R9 next write sets valid", 32'(next_valid), 1);
        wr(2'd0, 32'hD);
        wait_for_upd();
        chk("R4 upd flag after block", 32'(upd_flag), 1);
        chk("R9 valid cleared by promotion", 32'(next_valid), 0);
        stop_engine();
        for (int i = 0; i < 4; i++) begin
            chk("R2 burst address", log_addr[i], 32'h1000 + 32'(16 * i));
            chk("R2 burst length", 32'(log_len[i]), 4);
        end
        chk("R4 first burst of next block", log_addr[4], 32'h2000);
    endtask

    task automatic t_chain3();
        fresh();
        rdy_mode = 1; gnt_wait = 0;
        wr(2'd3, 32'h3000);
        wr(2'd1, 32'h7000);
        wr(2'd0, 32'h9);
        wait_for_upd();
        stop_engine();
        for (int i = 0; i < 6; i++) begin
            chk("R2 three-word address", log_addr[i], 32'h3000 + 32'(12 * i));
            chk("R2 three-word length", 32'(log_len[i]), 3);
        end
        chk("R4 crossing promotes", log_addr[6], 32'h7000);
    endtask

    task automatic t_overrun();
        fresh();
        rdy_mode = 0; gnt_wait = 0;
        wr(2'd3, 32'h4000);
        wr(2'd1, 32'h5000);
        wr(2'd0, 32'hD);
        for (int i = 0; i < 20000 && !ovr_flag; i++) @(negedge clk);
        chk("R5 overrun flagged", 32'(ovr_flag), 1);
        chk("R5 pointer at boundary", cur_ptr, 32'h5040);
        chk("R4 promoted once", log_addr[4], 32'h5000);
        repeat (40) @(negedge clk);
        chk("R5 no request while halted", 32'(log_n), 8);
        chk("R5 engine idle", 32'(busy), 0);
        wr(2'd1, 32'h6000);
        wr(2'd2, 32'h2);
        chk("R6 W1C clears overrun", 32'(ovr_flag), 0);
        for (int i = 0; i < 200 && log_n < 9; i++) @(negedge clk);
        chk("R5 resume at current pointer", log_addr[8], 32'h5040);
        stop_engine();
    endtask

    task automatic t_status();
        fresh();
        rdy_mode = 0;
        chk("R6 flags cleared", 32'(upd_flag), 0);
        wr(2'd3, 32'h9000);
        wr(2'd1, 32'hA000);
        wr(2'd0, 32'h1);
        wait_for_upd();
        stop_engine();
        chk("R2 one-word length", 32'(log_len[0]), 1);
        chk("R2 one-word step", log_addr[15], 32'h903C);
        chk("R4 one-word promotion", log_addr[16], 32'hA000);
        chk("R7 irq masked", 32'(irq), 0);
        wr(2'd0, 32'h2);
        chk("R7 irq enabled", 32'(irq), 1);
        wr(2'd2, 32'h0);
        chk("R6 write 0 keeps flag", 32'(upd_flag), 1);
        wr(2'd2, 32'h2);
        chk("R6 other bit keeps flag", 32'(upd_flag), 1);
        wr(2'd2, 32'h1);
        chk("R6 W1C clears update", 32'(upd_flag), 0);
        chk("R7 irq follows flag", 32'(irq), 0);
    endtask

    task automatic t_disable();
        int n;
        fresh();
        rdy_mode = 1;
        wr(2'd3, 32'hB000);
        wr(2'd1, 32'hC000);
        wr(2'd0, 32'hD);
        for (int i = 0; i < 500 && !dev_valid; i++) @(negedge clk);
        n = log_n;
        wr(2'd0, 32'h0);
        repeat (60) @(negedge clk);
        chk("R8 no request after disable", 32'(log_n), 32'(n));
        chk("R8 burst finished", 32'(exp_rd), 32'(exp_wr));
        chk("R8 pointer advanced once", cur_ptr, log_addr[n-1] + 32'h10);
        chk("R8 next pointer untouched", 32'(next_valid), 1);
        chk("R8 idle", 32'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_chain4();
        t_chain3();
        t_overrun();
        t_status();
        t_disable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule